// File: doc/BRIEF.md
# Interrupt Pending and Mask Front End

This block sits between 64 level-sensitive interrupt sources and a downstream priority encoder. On every clock it registers the state of each source into a pending vector. The pending vector always follows the raw source level, whatever the mask says. A per-source mask holds requests back: a mask bit of 1 blocks that source, and a 0 lets it through. The block drives the raw pending bits, the masked request vector and a single any-request flag.

Software reaches four 32-bit words over a simple register bus. The bus has a byte offset, a write strobe, write data and combinational read data. Two words are read-only views of the pending vector. The other two words hold the mask, which is readable and writable. At reset the mask is all ones, so every source starts blocked until software opens it.

Top module: `irq_gate_top`

## Requirements
- R1: On each rising clock edge, every pending bit takes the level of its source input. The new value is visible on `pend_out` after that edge. Reset clears the pending vector to zero.
- R2: A pending bit is 1 whenever its source was high at the last edge, even when the source's mask bit is 1.
- R3: Reading offset 0x00 returns pending bits for sources 32–63, with data bit n holding source 32+n. Reading offset 0x04 returns pending bits for sources 0–31, with data bit n holding source n.
- R4: A write to offset 0x00 or 0x04 changes neither the pending vector nor the mask.
- R5: The mask word for sources 32–63 is at offset 0x08, and the mask word for sources 0–31 is at offset 0x0C. Each uses the same bit order as R3. Both words can be read and written, and a write takes effect at the clock edge where the strobe is sampled.
- R6: Reset sets both mask words to 0xFFFFFFFF, so `req_out` and `req_any` are 0 after reset.
- R7: Each bit of `req_out` is 1 exactly when the matching pending bit is 1 and the matching mask bit is 0.
- R8: `req_any` is 1 exactly when at least one bit of `req_out` is 1.
- R9: When a write sets a mask bit for a source that is requesting, the matching `req_out` bit is 0 right after the edge that takes the write. No additional cycle of delay is added.
- R10: An offset whose two low bits are not both 0 reads as zero, and a write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level interrupt sources, bit i is source i |
| reg_addr | input | 4 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pend_out | output | 64 | Registered raw source state |
| req_out | output | 64 | Pending bits with masked sources removed |
| req_any | output | 1 | OR of all bits of `req_out` |

## Verification
A source level shows up on `pend_out` one edge after it is driven. `req_out`, `req_any` and bus reads of the pending words appear in the same cycle as `pend_out`, because they are combinational from the registered state. A mask write is visible on read-back and on `req_out` immediately after the edge that samples the strobe. To respect this, the bench drives inputs one time unit after an edge, advances exactly one edge, and samples outputs one time unit later. Read data is checked one time unit after the offset changes, with no clock edge in between. Each check therefore sits in the first cycle the requirement allows.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 2;
    localparam int NUM_SRC   = WORD_W * NUM_WORDS;
    localparam int ADDR_W    = 4;

    // Offset bits [3:2] choose the word; the order matters to software.
    typedef enum logic [1:0] {
        SEL_PEND_HI = 2'd0,
        SEL_PEND_LO = 2'd1,
        SEL_MASK_HI = 2'd2,
        SEL_MASK_LO = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.hit = (a[1:0] == 2'b00);
        d.sel = reg_sel_e'(a[3:2]);
        return d;
    endfunction

    // Word 1 carries sources 32..63 and word 0 carries sources 0..31.
    function automatic reg_sel_e mask_sel_for(input int w);
        return (w == 1) ? SEL_MASK_HI : SEL_MASK_LO;
    endfunction

    function automatic int word_of_sel(input reg_sel_e s);
        return (s == SEL_PEND_HI || s == SEL_MASK_HI) ? 1 : 0;
    endfunction

endpackage

// File: rtl/irq_pend_sampler.sv
module irq_pend_sampler
    import irq_gate_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NW = NUM_WORDS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W*NW-1:0] src,
    output logic [W*NW-1:0] pend
);
    for (genvar w = 0; w < NW; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) pend[w*W +: W] <= '0;
            else     pend[w*W +: W] <= src[w*W +: W];
        end
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_gate_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NW = NUM_WORDS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  reg_dec_t        dec,
    input  logic [W-1:0]    wdata,
    output logic [W*NW-1:0] mask
);
    for (genvar w = 0; w < NW; w++) begin : g_word
        localparam reg_sel_e MY_SEL = mask_sel_for(w);
        logic hit_w;
        assign hit_w = wr && dec.hit && (dec.sel == MY_SEL);
        always_ff @(posedge clk) begin
            if (rst)        mask[w*W +: W] <= '1;
            else if (hit_w) mask[w*W +: W] <= wdata;
        end
    end
endmodule

// File: rtl/irq_req_combine.sv
module irq_req_combine
    import irq_gate_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] mask,
    output logic [N-1:0] req,
    output logic         any
);
    always_comb begin
        req = pend & ~mask;
        any = |req;
    end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_gate_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NW = NUM_WORDS
) (
    input  reg_dec_t        dec,
    input  logic [W*NW-1:0] pend,
    input  logic [W*NW-1:0] mask,
    output logic [W-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        if (dec.hit) begin
            unique case (dec.sel)
                SEL_PEND_HI, SEL_PEND_LO:
                    rdata = pend[word_of_sel(dec.sel)*W +: W];
                SEL_MASK_HI, SEL_MASK_LO:
                    rdata = mask[word_of_sel(dec.sel)*W +: W];
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top
    import irq_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic [NUM_SRC-1:0] pend_out,
    output logic [NUM_SRC-1:0] req_out,
    output logic               req_any
);
    reg_dec_t           dec;
    logic [NUM_SRC-1:0] mask_q;

    assign dec = decode_addr(reg_addr);

    irq_pend_sampler #(.W(WORD_W), .NW(NUM_WORDS)) u_pend (
        .clk (clk), .rst (rst), .src (irq_in), .pend (pend_out)
    );

    irq_mask_bank #(.W(WORD_W), .NW(NUM_WORDS)) u_mask (
        .clk (clk), .rst (rst), .wr (reg_wr), .dec (dec),
        .wdata (reg_wdata), .mask (mask_q)
    );

    irq_req_combine #(.N(NUM_SRC)) u_req (
        .pend (pend_out), .mask (mask_q), .req (req_out), .any (req_any)
    );

    irq_read_mux #(.W(WORD_W), .NW(NUM_WORDS)) u_rd (
        .dec (dec), .pend (pend_out), .mask (mask_q), .rdata (reg_rdata)
    );
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk
    import irq_gate_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq_in,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_wr,
    input logic [WORD_W-1:0]  reg_wdata,
    input logic [WORD_W-1:0]  reg_rdata,
    input logic [NUM_SRC-1:0] pend_out,
    input logic [NUM_SRC-1:0] req_out,
    input logic               req_any,
    input logic [NUM_SRC-1:0] mask_q
);
    // R1 R2
    pend_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pend_out == $past(irq_in));

    // R6
    mask_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> mask_q == '1);

    // R5
    mask_lo_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'hC) |=> mask_q[WORD_W-1:0] == $past(reg_wdata));

    // R4 R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr || reg_addr[1:0] != 2'b00 || reg_addr[3:2] < 2'd2) |=> $stable(mask_q));

    // R7 R9
    req_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (req_out & (mask_q | ~pend_out)) == '0);

    // R8
    any_flag_chk: assert property (@(posedge clk) disable iff (rst)
        req_any |-> $countones(req_out) > 0);

    // R3
    pend_hi_read_chk: assert property (@(posedge clk) disable iff (rst)
        reg_addr == 4'h0 |-> reg_rdata == pend_out[NUM_SRC-1:WORD_W]);

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        reg_addr[1:0] != 2'b00 |-> reg_rdata == '0);
endmodule

bind irq_gate_top irq_gate_chk u_chk (
    .clk (clk), .rst (rst), .irq_in (irq_in), .reg_addr (reg_addr),
    .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .pend_out (pend_out), .req_out (req_out), .req_any (req_any),
    .mask_q (mask_q)
);

// File: tb/irq_gate_top_tb.sv
module irq_gate_top_tb;
    logic        clk = 0;
    logic        rst;
    logic [63:0] irq_in;
    logic [3:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [63:0] pend_out, req_out;
    logic        req_any;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_gate_top u_dut (
        .clk (clk), .rst (rst), .irq_in (irq_in), .reg_addr (reg_addr),
        .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .pend_out (pend_out), .req_out (req_out), .req_any (req_any)
    );

    // {source levels, mask}
    localparam logic [127:0] VEC [6] = '{
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
        {64'hA5A5_A5A5_A5A5_A5A5, 64'hFFFF_0000_FFFF_0000},
        {64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001},
        {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        {64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_0000_0000},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF}
    };

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        step();
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, input string req, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, {32'h0, reg_rdata}, {32'h0, exp});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; irq_in = '0; reg_addr = '0; reg_wr = 0; reg_wdata = '0;
        step(); step();
        irq_in = 64'hFFFF_FFFF_FFFF_FFFF;
        step();
        // R1 R6: reset state
        chk("R1 reset pend", pend_out, 64'h0);
        chk("R6 reset req", req_out, 64'h0);
        chk("R6 reset any", {63'h0, req_any}, 64'h0);
        rst = 0;
        rd(4'h8, "R6 mask hi reset", 32'hFFFF_FFFF);
        rd(4'hC, "R6 mask lo reset", 32'hFFFF_FFFF);
        step();
        // R2: all masked yet pending visible
        chk("R2 pend while masked", pend_out, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R6 req after reset", req_out, 64'h0);

        for (int i = 0; i < 6; i++) begin
            logic [63:0] s, m;
            s = VEC[i][127:64];
            m = VEC[i][63:0];
            wr(4'h8, m[63:32]);
            wr(4'hC, m[31:0]);
            rd(4'h8, "R5 mask hi read", m[63:32]);
            rd(4'hC, "R5 mask lo read", m[31:0]);
            irq_in = s;
            step();
            chk("R1 pend", pend_out, s);
            chk("R7 req", req_out, s & ~m);
            chk("R8 any", {63'h0, req_any}, {63'h0, |(s & ~m)});
            rd(4'h0, "R3 pend hi read", s[63:32]);
            rd(4'h4, "R3 pend lo read", s[31:0]);
        end

        // R1 timing: pend moves only at the edge
        wr(4'h8, 32'h0); wr(4'hC, 32'h0);
        irq_in = 64'h0000_0010_0000_0100;
        #2;
        chk("R1 before edge", pend_out, 64'hFFFF_FFFF_FFFF_FFFF);
        step();
        chk("R1 after edge", pend_out, 64'h0000_0010_0000_0100);

        // R4: writes to pending words ignored
        wr(4'h0, 32'hDEAD_BEEF);
        wr(4'h4, 32'h1357_9BDF);
        rd(4'h0, "R4 pend hi unchanged", 32'h0000_0010);
        rd(4'h4, "R4 pend lo unchanged", 32'h0000_0100);
        rd(4'h8, "R4 mask hi unchanged", 32'h0);
        rd(4'hC, "R4 mask lo unchanged", 32'h0);

        // R9: masking drops the request right after the write edge
        chk("R9 req before mask", req_out, 64'h0000_0010_0000_0100);
        wr(4'hC, 32'h0000_0100);
        chk("R9 lo req dropped", req_out, 64'h0000_0010_0000_0000);
        wr(4'h8, 32'h0000_0010);
        chk("R9 hi req dropped", req_out, 64'h0);
        chk("R9 any dropped", {63'h0, req_any}, 64'h0);

        // R10: unmapped offsets
        rd(4'h2, "R10 unmapped read", 32'h0);
        rd(4'h9, "R10 unmapped read", 32'h0);
        wr(4'hD, 32'hFFFF_0000);
        wr(4'hB, 32'h0000_FFFF);
        rd(4'hC, "R10 mask lo kept", 32'h0000_0100);
        rd(4'h8, "R10 mask hi kept", 32'h0000_0010);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule